// File: doc/BRIEF.md
# Dual-Channel Prescaled Down-Counting Timer

This block holds two independent countdown timers behind a small register bus with a valid, write, address and data interface. Software gives a channel a start value and turns it on, and the channel then counts down by one per step. A step comes on every clock cycle, on every 16th cycle or on every 256th cycle. When a count runs out, the channel latches an expiry flag. In auto-reload mode it starts again from its start value; otherwise it stays at zero. The time elapsed since the last expiry is the start value minus the live count.

Each channel has an interrupt-enable bit. A single interrupt line is the OR of the enabled expiry flags of both channels. The flags can be read through a status word whether or not the interrupt is enabled. Software acknowledges an expiry by writing any value to the channel's clear register. A channel is stopped by writing zero to its control register, and while it is stopped its start value and live count can be rewritten. Reads are combinational from the address, so read data is valid in the same cycle.

Top module: `dual_tick_timer`

## Requirements
- R1: After a synchronous active-low reset, every register of both channels reads 0 and `irq_out` is low.
- R2: Channel n occupies addresses 0x20*n to 0x20*n+0x1F. The word offsets within a channel are: start value 0x00, live count 0x04, control 0x08, clear 0x0C and status 0x10. In the status word, bit 0 is the raw expiry flag and bit 1 is the flag ANDed with the interrupt enable. Control bits 4, 1 and 0 are reserved, read as 0 and are not stored.
- R3: Control bit 7 enables counting, and control bits 3:2 set the step rate. A setting of 00 or 11 steps every cycle, 01 steps every 16th cycle and 10 steps every 256th cycle. Any control write restarts the rate divider, so the first step falls 1, 16 or 256 cycles after the enabling write.
- R4: A write to the start-value register updates the start value and the live count together. A write to the live-count register updates the live count alone.
- R5: A step that takes the count from 1 down to 0 sets the channel's raw expiry flag. If control bit 6 (auto-reload) is set, the count takes the start value instead of 0. Otherwise the count stays at 0, and later steps neither change it nor set the flag.
- R6: The raw expiry flag is set whether or not control bit 5 (interrupt enable) is set. `irq_out` is high exactly when some channel has both its raw flag and its interrupt enable set.
- R7: Any write to a channel's clear register drops its raw flag. If an expiry happens in the same cycle as the clear, the flag stays set.
- R8: While control bit 7 is 0, the live count holds its value except for register writes.
- R9: The two channels are independent. Register traffic to one channel and counting in one channel leave the other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one count tick before the divider |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Qualifies a register write |
| bus_write | input | 1 | 1 selects a write when bus_valid is high |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Combined interrupt of both channels |

## Verification
The bench targets the boundaries of the rate divider. A design that forgot to restart the divider on a control write, or that was off by one, would show the 16-cycle rate one cycle early or late, and a design that gave the reserved setting 11 its own meaning would miss the every-cycle rate. The bench lets an auto-reload channel run past zero so that a design which parks at zero, or which reloads one step late, returns the wrong count. It places a clear in the same cycle as a second expiry, where a design that let the clear win would lose the interrupt. It also checks that an expiry with the interrupt disabled is visible in the status word while the interrupt line stays low.

// File: rtl/tmr_pkg.sv
// Shared types and register offsets for the dual-channel timer.
// Assumes a 32-bit data path and an 8-bit control word per channel.
package tmr_pkg;

    localparam int CTRL_W = 8;

    // Control word, MSB first: bit 7 run, 6 auto-reload, 5 irq enable,
    // 4 reserved, 3:2 step rate, 1:0 reserved.
    typedef struct packed {
        logic       run;
        logic       auto_reload;
        logic       irq_en;
        logic       rsv_hi;
        logic [1:0] rate;
        logic [1:0] rsv_lo;
    } tmr_ctrl_t;

    localparam logic [1:0] RATE_16  = 2'b01;
    localparam logic [1:0] RATE_256 = 2'b10;

    localparam logic [7:0] OFF_START  = 8'h00;
    localparam logic [7:0] OFF_COUNT  = 8'h04;
    localparam logic [7:0] OFF_CTRL   = 8'h08;
    localparam logic [7:0] OFF_CLEAR  = 8'h0C;
    localparam logic [7:0] OFF_STATUS = 8'h10;

    // Turn a written byte into a control word with the reserved bits cleared.
    function automatic tmr_ctrl_t ctrl_from_byte(input logic [CTRL_W-1:0] b);
        tmr_ctrl_t c;
        c        = tmr_ctrl_t'(b);
        c.rsv_hi = 1'b0;
        c.rsv_lo = 2'b00;
        return c;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Step generator for one timer channel.
// A free-running phase counter is held at zero while the channel is idle
// or while its control register is being written. The step output pulses
// once per 1, 2**MID_LOG or 2**SLOW_LOG cycles, as the rate setting picks.
// Assumes MID_LOG < SLOW_LOG.
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int MID_LOG  = 4,
    parameter int SLOW_LOG = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] rate,
    output logic       step
);

    logic [SLOW_LOG-1:0] phase;

    // Advance the phase while running; restart it on idle or reconfiguration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart || !run) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Pulse on the last phase of the selected period; the reserved setting steps every cycle.
    always_comb begin
        case (rate)
            RATE_16:  step = run && (&phase[MID_LOG-1:0]);
            RATE_256: step = run && (&phase);
            default:  step = run;
        endcase
    end

endmodule

// File: rtl/tmr_channel.sv
// One down-counting timer channel: start value, live count, control word
// and raw expiry flag. Register writes take priority over counting.
// An expiry (a step from 1 to 0) sets the flag, and setting beats clearing.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MID_LOG  = 4,
    parameter int SLOW_LOG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_count,
    input  logic              wr_ctrl,
    input  logic              wr_clear,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] start_q,
    output logic [DATA_W-1:0] count_q,
    output tmr_ctrl_t         ctrl_q,
    output logic              raw_q
);

    logic step;
    logic at_one;
    logic at_zero;
    logic expire;

    tmr_prescaler #(
        .MID_LOG  (MID_LOG),
        .SLOW_LOG (SLOW_LOG)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.run),
        .restart (wr_ctrl),
        .rate    (ctrl_q.rate),
        .step    (step)
    );

    assign at_one  = (count_q == DATA_W'(1));
    assign at_zero = (count_q == '0);
    assign expire  = step && at_one && !wr_start && !wr_count;

    // Hold the start value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (wr_start) begin
            start_q <= wdata;
        end
    end

    // Hold the control word with its reserved bits cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_from_byte(wdata[CTRL_W-1:0]);
        end
    end

    // Count down on each step; reload or park at zero when the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (wr_start || wr_count) begin
            count_q <= wdata;
        end else if (step) begin
            if (at_one || at_zero) begin
                count_q <= ctrl_q.auto_reload ? start_q : '0;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    // Latch the expiry flag; a clear in the same cycle as an expiry loses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (expire) begin
            raw_q <= 1'b1;
        end else if (wr_clear) begin
            raw_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dual_tick_timer.sv
// Register-mapped timer with N_CH independent down-counting channels.
// Address bits above CH_SHIFT select the channel and the low bits select the register.
// Writes are qualified by bus_valid and bus_write. Read data is a
// combinational function of bus_addr. irq_out is the OR of the enabled flags.
module dual_tick_timer
    import tmr_pkg::*;
#(
    parameter int N_CH      = 2,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CH_STRIDE = 32,
    parameter int MID_LOG   = 4,
    parameter int SLOW_LOG  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    localparam int CH_SHIFT = $clog2(CH_STRIDE);
    localparam int SEL_W    = ADDR_W - CH_SHIFT;

    localparam logic [CH_SHIFT-1:0] O_START  = OFF_START[CH_SHIFT-1:0];
    localparam logic [CH_SHIFT-1:0] O_COUNT  = OFF_COUNT[CH_SHIFT-1:0];
    localparam logic [CH_SHIFT-1:0] O_CTRL   = OFF_CTRL[CH_SHIFT-1:0];
    localparam logic [CH_SHIFT-1:0] O_CLEAR  = OFF_CLEAR[CH_SHIFT-1:0];
    localparam logic [CH_SHIFT-1:0] O_STATUS = OFF_STATUS[CH_SHIFT-1:0];

    logic [SEL_W-1:0]    ch_sel;
    logic [CH_SHIFT-1:0] reg_off;
    logic                wr;

    logic [DATA_W-1:0] start_arr [N_CH];
    logic [DATA_W-1:0] cnt_arr   [N_CH];
    tmr_ctrl_t         ctrl_arr  [N_CH];
    logic [N_CH-1:0]   raw_vec;
    logic [N_CH-1:0]   ie_vec;
    logic [N_CH-1:0]   en_vec;

    assign ch_sel  = bus_addr[ADDR_W-1:CH_SHIFT];
    assign reg_off = bus_addr[CH_SHIFT-1:0];
    assign wr      = bus_valid && bus_write;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic hit;
        assign hit = wr && (ch_sel == SEL_W'(g));

        tmr_channel #(
            .DATA_W   (DATA_W),
            .MID_LOG  (MID_LOG),
            .SLOW_LOG (SLOW_LOG)
        ) u_channel (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_start (hit && (reg_off == O_START)),
            .wr_count (hit && (reg_off == O_COUNT)),
            .wr_ctrl  (hit && (reg_off == O_CTRL)),
            .wr_clear (hit && (reg_off == O_CLEAR)),
            .wdata    (bus_wdata),
            .start_q  (start_arr[g]),
            .count_q  (cnt_arr[g]),
            .ctrl_q   (ctrl_arr[g]),
            .raw_q    (raw_vec[g])
        );

        assign ie_vec[g] = ctrl_arr[g].irq_en;
        assign en_vec[g] = ctrl_arr[g].run;
    end

    // Combined interrupt: any channel whose flag and enable are both set.
    assign irq_out = |(raw_vec & ie_vec);

    // Return the addressed register of the selected channel; anything else reads zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (ch_sel == SEL_W'(i)) begin
                case (reg_off)
                    O_START:  bus_rdata = start_arr[i];
                    O_COUNT:  bus_rdata = cnt_arr[i];
                    O_CTRL:   bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_arr[i]};
                    O_STATUS: bus_rdata = {{(DATA_W-2){1'b0}}, raw_vec[i] & ie_vec[i], raw_vec[i]};
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/tmr_checker.sv
// Property checker for dual_tick_timer, attached by bind. It watches channel 0's
// count and flags and the bus traffic that targets channel 0.
// Assumes channel 0 sits at the bottom of the address map.
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_out,
    input logic [N_CH-1:0]   raw_vec,
    input logic [N_CH-1:0]   ie_vec,
    input logic              run0,
    input logic [DATA_W-1:0] cnt0,
    input logic [DATA_W-1:0] start0
);

    logic wr_any;
    logic wr0_start;
    logic wr0_count;
    logic wr0_clear;

    assign wr_any    = bus_valid && bus_write;
    assign wr0_start = wr_any && (bus_addr == ADDR_W'(OFF_START));
    assign wr0_count = wr_any && (bus_addr == ADDR_W'(OFF_COUNT));
    assign wr0_clear = wr_any && (bus_addr == ADDR_W'(OFF_CLEAR));

    // R1: leaving reset, no flag is set and the interrupt line is low.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (raw_vec == '0) && !irq_out);

    // R4: a start-value write loads both the start value and the live count.
    p_start_loads_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr0_start |=> (cnt0 == $past(bus_wdata)) && (start0 == $past(bus_wdata)));

    // R3: a running count without writes holds, drops by one, reloads or parks.
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run0 && !wr0_start && !wr0_count |=>
            (cnt0 == $past(cnt0)) || (cnt0 == $past(cnt0) - 1'b1) ||
            (cnt0 == $past(start0)) || (cnt0 == '0));

    // R8: a stopped channel keeps its count unless software writes it.
    p_stopped_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run0 && !wr0_start && !wr0_count |=> $stable(cnt0));

    // R5: the flag rises only when the count has just run out or reloaded.
    p_flag_at_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_vec[0]) |-> (cnt0 == '0) || (cnt0 == start0));

    // R7: the flag only falls after a write to the clear register.
    p_flag_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_vec[0]) |-> $past(wr0_clear));

    // R6: the interrupt line needs a channel with both flag and enable set.
    p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((raw_vec & ie_vec) != '0));

endmodule

bind dual_tick_timer tmr_checker #(
    .N_CH   (N_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_tmr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .raw_vec   (raw_vec),
    .ie_vec    (ie_vec),
    .run0      (en_vec[0]),
    .cnt0      (cnt_arr[0]),
    .start0    (start_arr[0])
);

// File: tb/dual_tick_timer_bench.sv
// Self-checking bench for dual_tick_timer. Inputs change on the falling edge
// and outputs are sampled 1 ns after it. A table of vectors comes first,
// followed by directed tests for reset and the corner cases.
module dual_tick_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid;
    logic        bus_write;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dual_tick_timer u_dual_tick_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // Register offsets and channel bases (R2).
    localparam logic [7:0] A_START = 8'h00, A_COUNT = 8'h04, A_CTRL = 8'h08,
                           A_CLEAR = 8'h0C, A_STAT  = 8'h10;
    localparam logic [7:0] CH1 = 8'h20;

    // Vector table: channel, start value, control, cycles waited, expected count, expected status.
    localparam int NV = 6;
    localparam int          V_CH   [NV] = '{0, 1, 0, 1, 0, 1};
    localparam logic [31:0] V_LOAD [NV] = '{100, 100, 1000, 50, 20, 20};
    localparam logic [31:0] V_CTRL [NV] = '{32'h80, 32'h84, 32'h88, 32'h8C, 32'hE0, 32'h80};
    localparam int          V_WAIT [NV] = '{10, 40, 600, 7, 25, 25};
    localparam logic [31:0] V_EXPV [NV] = '{90, 98, 998, 43, 15, 0};
    localparam logic [31:0] V_EXPS [NV] = '{0, 0, 0, 0, 3, 1};

    // Drive one write from a falling edge through the next rising edge.
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_wdata = '0;
    endtask

    // Combinational read; no clock edge is consumed.
    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        rst_n     = 1'b0;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state.
        bus_rd(A_COUNT, rd);       chk("R1", "ch0 count after reset", rd, 0);
        bus_rd(CH1 | A_CTRL, rd);  chk("R1", "ch1 control after reset", rd, 0);
        bus_rd(A_STAT, rd);        chk("R1", "ch0 status after reset", rd, 0);
        chk("R1", "irq after reset", {31'b0, irq_out}, 0);

        // Vector walk: R3 rates and R5 expiry behaviour.
        for (int v = 0; v < NV; v++) begin
            logic [7:0] base;
            base = (V_CH[v] == 1) ? CH1 : 8'h00;
            bus_wr(base | A_CTRL, 0);
            bus_wr(base | A_CLEAR, 0);
            bus_wr(base | A_START, V_LOAD[v]);
            bus_wr(base | A_CTRL, V_CTRL[v]);
            wait_cyc(V_WAIT[v]);
            bus_rd(base | A_COUNT, rd); chk("R3", $sformatf("vector %0d count", v), rd, V_EXPV[v]);
            bus_rd(base | A_STAT, rd);  chk("R5", $sformatf("vector %0d status", v), rd, V_EXPS[v]);
        end

        // Stop both channels and drop their flags.
        bus_wr(A_CTRL, 0);
        bus_wr(CH1 | A_CTRL, 0);
        bus_wr(A_CLEAR, 0);
        bus_wr(CH1 | A_CLEAR, 0);

        // R2: reserved control bits are not stored.
        bus_wr(CH1 | A_CTRL, 32'h1F);
        bus_rd(CH1 | A_CTRL, rd);  chk("R2", "reserved control bits", rd, 32'h0C);
        bus_wr(CH1 | A_CTRL, 0);

        // R4: a live-count write leaves the start value alone.
        bus_wr(A_COUNT, 7);
        bus_rd(A_COUNT, rd);       chk("R4", "count after count write", rd, 7);
        bus_rd(A_START, rd);       chk("R4", "start kept after count write", rd, 20);

        // R8 and R9: a stopped channel holds; the idle channel is untouched.
        bus_wr(CH1 | A_COUNT, 33);
        bus_wr(A_START, 100);
        bus_wr(A_CTRL, 32'h80);
        wait_cyc(5);
        bus_rd(A_COUNT, rd);       chk("R3", "ch0 after 5 steps", rd, 95);
        bus_wr(A_CTRL, 0);         // one last step lands on this edge
        wait_cyc(10);
        bus_rd(A_COUNT, rd);       chk("R8", "stopped count holds", rd, 94);
        bus_rd(CH1 | A_COUNT, rd); chk("R9", "ch1 untouched by ch0", rd, 33);

        // R6: the flag is set without enable, and the line follows the enabled flag.
        bus_wr(A_START, 2);
        bus_wr(A_CTRL, 32'h80);
        wait_cyc(2);
        bus_rd(A_STAT, rd);        chk("R6", "flag without enable", rd, 1);
        chk("R6", "irq low without enable", {31'b0, irq_out}, 0);
        bus_wr(CH1 | A_START, 3);
        bus_wr(CH1 | A_CTRL, 32'hA0);
        wait_cyc(2);
        chk("R6", "irq before ch1 expiry", {31'b0, irq_out}, 0);
        wait_cyc(1);
        chk("R6", "irq at ch1 expiry", {31'b0, irq_out}, 1);
        bus_rd(CH1 | A_STAT, rd);  chk("R6", "ch1 status enabled flag", rd, 3);

        // R7: a clear drops the flag and the line.
        bus_wr(CH1 | A_CLEAR, 32'h5A);
        chk("R7", "irq after clear", {31'b0, irq_out}, 0);
        bus_rd(CH1 | A_STAT, rd);  chk("R7", "ch1 status after clear", rd, 0);
        bus_rd(CH1 | A_COUNT, rd); chk("R5", "one-shot parks at zero", rd, 0);

        // R7: a clear in the same cycle as an expiry loses; R5 reload.
        bus_wr(A_CTRL, 0);
        bus_wr(A_CLEAR, 0);
        bus_wr(A_START, 5);
        bus_wr(A_CTRL, 32'hE0);
        wait_cyc(4);
        bus_rd(A_STAT, rd);        chk("R5", "no flag before expiry", rd, 0);
        wait_cyc(5);
        bus_wr(A_CLEAR, 0);        // lands on the second expiry edge
        bus_rd(A_STAT, rd);        chk("R7", "expiry beats clear", rd, 3);
        bus_rd(A_COUNT, rd);       chk("R5", "auto-reload to start", rd, 5);
        bus_wr(A_CLEAR, 0);
        bus_rd(A_STAT, rd);        chk("R7", "clear away from expiry", rd, 0);
        bus_wr(A_CTRL, 0);

        // R3: first step at the 16-cycle rate lands exactly 16 cycles after enabling.
        bus_wr(CH1 | A_CTRL, 0);
        bus_wr(CH1 | A_START, 10);
        bus_wr(CH1 | A_CTRL, 32'h84);
        wait_cyc(15);
        bus_rd(CH1 | A_COUNT, rd); chk("R3", "no step before cycle 16", rd, 10);
        wait_cyc(1);
        bus_rd(CH1 | A_COUNT, rd); chk("R3", "first step at cycle 16", rd, 9);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule